// File: doc/BRIEF.md
# Two-Player Collect-the-Counter Game Controller

This block runs a two-player reflex game. A shared tally climbs by one on each random increment pulse. Either player may press a button to take the current tally as points, which empties the tally. Each player has a fixed number of takes. A clock register counts down once per second tick. The game ends when both players have used all their takes, or when a tick finds the clock already at zero. At that point the two scores are replaced by verdict codes.

The game rules are not built from dedicated counters. A sequencer drives single-cycle micro-steps through one shared datapath: a register file with two read ports and one write port, two operand multiplexers that can also supply fixed constants, a small ALU (add, subtract, compare), and a write-data multiplexer that can also supply verdict codes. Each rule works in three steps. A compare writes its 0/1 result to a scratch register. The next state branches on bit 0 of that register. Then the update steps run. Scores, tally and clock are taken straight from the register file for display.

Top module: `duel_tally_core`

## Requirements
- R1: While `rst` is high and in the cycle after it, both scores and the tally read 0 and `game_over` is 0. Within four cycles after `rst` falls, `time_left` reads 30.
- R2: Each `bump` pulse adds one to `tally`.
- R3: A press from a player with fewer than 3 takes adds `tally` to that player's score, then clears `tally` to 0.
- R4: A press from a player who already has 3 takes changes neither score nor `tally`.
- R5: A `sec_tick` lowers `time_left` by one when it is above zero. A `sec_tick` that finds `time_left` at zero ends the game. `time_left` never goes above 30.
- R6: The press that gives both players 3 takes ends the game at once, whatever the value of `time_left`.
- R7: At game end, the higher score becomes 0xFFFF and the lower becomes 0x0000. If the scores are equal, both become 0x000F. `game_over` rises only after both verdict codes are written.
- R8: Pending events are served one at a time in this order: player 1 press, player 2 press, tick, bump. A pulse that arrives while another event is being served is held until it can be served.
- R9: Once `game_over` is 1, it stays 1. Scores, `tally` and `time_left` then hold still until `rst`, whatever pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high restart; clears all registers and starts a new game |
| hit1 | input | 1 | One-cycle press pulse from player 1 |
| hit2 | input | 1 | One-cycle press pulse from player 2 |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bump | input | 1 | One-cycle random increment pulse |
| p1_score | output | 16 | Player 1 score, or verdict code at game end |
| p2_score | output | 16 | Player 2 score, or verdict code at game end |
| tally | output | 16 | Current collectible value |
| time_left | output | 16 | Seconds remaining |
| game_over | output | 1 | High once the verdict is written |

## Verification
The assertions check these on every cycle: the cleared state after restart, that the tally only steps up by one or drops to zero, that the clock only counts down by one or reloads to 30 and never exceeds 30, that the end state is frozen, and that the verdict pair is one of the three legal codes when `game_over` rises. Only the bench scenarios can show the rest. That covers the point values credited on a press, a fourth press being ignored, the service order of pulses that arrive in the same cycle, a pulse held while another event is served, and which of the two end conditions closes the game.

// File: rtl/duel_pkg.sv
package duel_pkg;

    localparam int unsigned ADDR_W = 4;

    // fixed register homes inside the register bank
    localparam logic [ADDR_W-1:0] RA_SCORE0  = 4'h0;
    localparam logic [ADDR_W-1:0] RA_SCORE1  = 4'h1;
    localparam logic [ADDR_W-1:0] RA_USES0   = 4'h2;
    localparam logic [ADDR_W-1:0] RA_USES1   = 4'h3;
    localparam logic [ADDR_W-1:0] RA_TALLY   = 4'h7;
    localparam logic [ADDR_W-1:0] RA_CLOCK   = 4'h8;
    localparam logic [ADDR_W-1:0] RA_SCRATCH = 4'hF;

    typedef enum logic [5:0] {
        ALU_ADD   = 6'b000000,
        ALU_SUB   = 6'b000001,
        ALU_CMPEQ = 6'b110011,
        ALU_CMPLT = 6'b110101,
        ALU_CMPLE = 6'b110111
    } alu_op_e;

    typedef enum logic [1:0] {A_REG = 2'b00, A_ONE = 2'b01, A_ZERO = 2'b10, A_INIT = 2'b11} asel_e;
    typedef enum logic [1:0] {B_REG = 2'b00, B_ONE = 2'b01, B_ZERO = 2'b10, B_LIMIT = 2'b11} bsel_e;
    typedef enum logic [1:0] {W_ALU = 2'b00, W_WIN = 2'b01, W_LOSE = 2'b10, W_DRAW = 2'b11} wdsel_e;

    typedef struct packed {
        alu_op_e           op;
        asel_e             asel;
        bsel_e             bsel;
        wdsel_e            wdsel;
        logic [ADDR_W-1:0] ra;
        logic [ADDR_W-1:0] rb;
        logic [ADDR_W-1:0] rc;
        logic              we;
    } ctrl_t;

    typedef enum logic [4:0] {
        S_BOOT, S_IDLE,
        S_PCMP, S_PBR, S_PINC, S_PADD, S_PCLR,
        S_D1CMP, S_D1BR, S_D2CMP, S_D2BR,
        S_TCMP, S_TBR, S_TDEC,
        S_BUMP,
        S_WLT, S_WLTBR, S_WEQ, S_WEQBR,
        S_HI_A, S_HI_B, S_LO_A, S_LO_B, S_DR_A, S_DR_B,
        S_OVER
    } seq_state_e;

endpackage

// File: rtl/duel_regbank.sv
module duel_regbank #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned ADDR_W = 4,
    parameter logic [4*ADDR_W-1:0] TAP_ADDR = {4'h8, 4'h7, 4'h1, 4'h0}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       wa,
    input  logic [WIDTH-1:0]        wd,
    input  logic [ADDR_W-1:0]       ra,
    input  logic [ADDR_W-1:0]       rb,
    output logic [WIDTH-1:0]        rd_a,
    output logic [WIDTH-1:0]        rd_b,
    output logic [3:0][WIDTH-1:0]   taps
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] regs_q [DEPTH];
    logic [WIDTH-1:0] regs_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) regs_d[i] = regs_q[i];
        if (we) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) regs_q[i] <= rst ? '0 : regs_d[i];
    end

    assign rd_a = regs_q[ra];
    assign rd_b = regs_q[rb];

    for (genvar g = 0; g < 4; g++) begin : g_tap
        assign taps[g] = regs_q[TAP_ADDR[g*ADDR_W +: ADDR_W]];
    end
endmodule

// File: rtl/duel_alu.sv
module duel_alu
    import duel_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        y = '0;
        case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_CMPEQ: y[0] = (a == b);
            ALU_CMPLT: y[0] = (a < b);
            ALU_CMPLE: y[0] = (a <= b);
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/duel_seq.sv
module duel_seq
    import duel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit1,
    input  logic  hit2,
    input  logic  tick,
    input  logic  bump,
    input  logic  flag,
    output ctrl_t ctrl,
    output logic  over
);
    typedef struct packed {
        seq_state_e st;
        logic       who;
        logic [3:0] pend;   // [0] p1, [1] p2, [2] tick, [3] bump
    } seq_t;

    seq_t cur_q, nx_d;
    logic [ADDR_W-1:0] a_uses, a_score;
    logic [3:0] arrive;

    assign a_uses  = cur_q.who ? RA_USES1  : RA_USES0;
    assign a_score = cur_q.who ? RA_SCORE1 : RA_SCORE0;
    assign arrive  = {bump, tick, hit2, hit1};

    always_comb begin
        nx_d      = cur_q;
        nx_d.pend = cur_q.pend | arrive;

        ctrl.op    = ALU_ADD;
        ctrl.asel  = A_REG;
        ctrl.bsel  = B_ZERO;
        ctrl.wdsel = W_ALU;
        ctrl.ra    = '0;
        ctrl.rb    = '0;
        ctrl.rc    = '0;
        ctrl.we    = 1'b0;

        case (cur_q.st)
            S_BOOT: begin
                ctrl.asel = A_INIT; ctrl.bsel = B_ZERO;
                ctrl.rc = RA_CLOCK; ctrl.we = 1'b1;
                nx_d.st = S_IDLE;
            end
            S_IDLE: begin
                if (cur_q.pend[0]) begin
                    nx_d.who = 1'b0; nx_d.pend[0] = arrive[0]; nx_d.st = S_PCMP;
                end else if (cur_q.pend[1]) begin
                    nx_d.who = 1'b1; nx_d.pend[1] = arrive[1]; nx_d.st = S_PCMP;
                end else if (cur_q.pend[2]) begin
                    nx_d.pend[2] = arrive[2]; nx_d.st = S_TCMP;
                end else if (cur_q.pend[3]) begin
                    nx_d.pend[3] = arrive[3]; nx_d.st = S_BUMP;
                end
            end
            S_PCMP: begin
                ctrl.op = ALU_CMPLT; ctrl.ra = a_uses; ctrl.bsel = B_LIMIT;
                ctrl.rc = RA_SCRATCH; ctrl.we = 1'b1;
                nx_d.st = S_PBR;
            end
            S_PBR: begin
                ctrl.rb = RA_SCRATCH;
                nx_d.st = flag ? S_PINC : S_IDLE;
            end
            S_PINC: begin
                ctrl.ra = a_uses; ctrl.bsel = B_ONE;
                ctrl.rc = a_uses; ctrl.we = 1'b1;
                nx_d.st = S_PADD;
            end
            S_PADD: begin
                ctrl.ra = a_score; ctrl.rb = RA_TALLY; ctrl.bsel = B_REG;
                ctrl.rc = a_score; ctrl.we = 1'b1;
                nx_d.st = S_PCLR;
            end
            S_PCLR: begin
                ctrl.asel = A_ZERO; ctrl.bsel = B_ZERO;
                ctrl.rc = RA_TALLY; ctrl.we = 1'b1;
                nx_d.st = S_D1CMP;
            end
            S_D1CMP: begin
                ctrl.op = ALU_CMPEQ; ctrl.ra = RA_USES0; ctrl.bsel = B_LIMIT;
                ctrl.rc = RA_SCRATCH; ctrl.we = 1'b1;
                nx_d.st = S_D1BR;
            end
            S_D1BR: begin
                ctrl.rb = RA_SCRATCH;
                nx_d.st = flag ? S_D2CMP : S_IDLE;
            end
            S_D2CMP: begin
                ctrl.op = ALU_CMPEQ; ctrl.ra = RA_USES1; ctrl.bsel = B_LIMIT;
                ctrl.rc = RA_SCRATCH; ctrl.we = 1'b1;
                nx_d.st = S_D2BR;
            end
            S_D2BR: begin
                ctrl.rb = RA_SCRATCH;
                nx_d.st = flag ? S_WLT : S_IDLE;
            end
            S_TCMP: begin
                ctrl.op = ALU_CMPEQ; ctrl.ra = RA_CLOCK; ctrl.bsel = B_ZERO;
                ctrl.rc = RA_SCRATCH; ctrl.we = 1'b1;
                nx_d.st = S_TBR;
            end
            S_TBR: begin
                ctrl.rb = RA_SCRATCH;
                nx_d.st = flag ? S_WLT : S_TDEC;
            end
            S_TDEC: begin
                ctrl.op = ALU_SUB; ctrl.ra = RA_CLOCK; ctrl.bsel = B_ONE;
                ctrl.rc = RA_CLOCK; ctrl.we = 1'b1;
                nx_d.st = S_IDLE;
            end
            S_BUMP: begin
                ctrl.ra = RA_TALLY; ctrl.bsel = B_ONE;
                ctrl.rc = RA_TALLY; ctrl.we = 1'b1;
                nx_d.st = S_IDLE;
            end
            S_WLT: begin
                ctrl.op = ALU_CMPLT; ctrl.ra = RA_SCORE0; ctrl.rb = RA_SCORE1;
                ctrl.bsel = B_REG; ctrl.rc = RA_SCRATCH; ctrl.we = 1'b1;
                nx_d.st = S_WLTBR;
            end
            S_WLTBR: begin
                ctrl.rb = RA_SCRATCH;
                nx_d.st = flag ? S_LO_A : S_WEQ;
            end
            S_WEQ: begin
                ctrl.op = ALU_CMPEQ; ctrl.ra = RA_SCORE0; ctrl.rb = RA_SCORE1;
                ctrl.bsel = B_REG; ctrl.rc = RA_SCRATCH; ctrl.we = 1'b1;
                nx_d.st = S_WEQBR;
            end
            S_WEQBR: begin
                ctrl.rb = RA_SCRATCH;
                nx_d.st = flag ? S_DR_A : S_HI_A;
            end
            S_HI_A: begin ctrl.wdsel = W_WIN;  ctrl.rc = RA_SCORE0; ctrl.we = 1'b1; nx_d.st = S_HI_B; end
            S_HI_B: begin ctrl.wdsel = W_LOSE; ctrl.rc = RA_SCORE1; ctrl.we = 1'b1; nx_d.st = S_OVER; end
            S_LO_A: begin ctrl.wdsel = W_LOSE; ctrl.rc = RA_SCORE0; ctrl.we = 1'b1; nx_d.st = S_LO_B; end
            S_LO_B: begin ctrl.wdsel = W_WIN;  ctrl.rc = RA_SCORE1; ctrl.we = 1'b1; nx_d.st = S_OVER; end
            S_DR_A: begin ctrl.wdsel = W_DRAW; ctrl.rc = RA_SCORE0; ctrl.we = 1'b1; nx_d.st = S_DR_B; end
            S_DR_B: begin ctrl.wdsel = W_DRAW; ctrl.rc = RA_SCORE1; ctrl.we = 1'b1; nx_d.st = S_OVER; end
            S_OVER: begin
                nx_d.pend = '0;
            end
            default: nx_d.st = S_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st   <= S_BOOT;
            cur_q.who  <= 1'b0;
            cur_q.pend <= '0;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign over = (cur_q.st == S_OVER);
endmodule

// File: rtl/duel_tally_core.sv
module duel_tally_core
    import duel_pkg::*;
#(
    parameter int unsigned WIDTH     = 16,
    parameter int unsigned TIME_INIT = 30,
    parameter int unsigned USES_MAX  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit1,
    input  logic             hit2,
    input  logic             sec_tick,
    input  logic             bump,
    output logic [WIDTH-1:0] p1_score,
    output logic [WIDTH-1:0] p2_score,
    output logic [WIDTH-1:0] tally,
    output logic [WIDTH-1:0] time_left,
    output logic             game_over
);
    localparam logic [WIDTH-1:0] K_INIT  = WIDTH'(TIME_INIT);
    localparam logic [WIDTH-1:0] K_LIMIT = WIDTH'(USES_MAX);
    localparam logic [WIDTH-1:0] K_DRAW  = WIDTH'(16'h000F);
    localparam logic [4*ADDR_W-1:0] TAPS = {RA_CLOCK, RA_TALLY, RA_SCORE1, RA_SCORE0};

    ctrl_t                 ctrl;
    logic [WIDTH-1:0]      rd_a, rd_b, op_a, op_b, alu_y, wr_data;
    logic [3:0][WIDTH-1:0] taps;

    duel_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .hit1 (hit1),
        .hit2 (hit2),
        .tick (sec_tick),
        .bump (bump),
        .flag (rd_b[0]),
        .ctrl (ctrl),
        .over (game_over)
    );

    duel_regbank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .TAP_ADDR(TAPS)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (ctrl.we),
        .wa   (ctrl.rc),
        .wd   (wr_data),
        .ra   (ctrl.ra),
        .rb   (ctrl.rb),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .taps (taps)
    );

    duel_alu #(.WIDTH(WIDTH)) u_alu (
        .op (ctrl.op),
        .a  (op_a),
        .b  (op_b),
        .y  (alu_y)
    );

    always_comb begin
        case (ctrl.asel)
            A_REG:   op_a = rd_a;
            A_ONE:   op_a = WIDTH'(1);
            A_ZERO:  op_a = '0;
            default: op_a = K_INIT;
        endcase
        case (ctrl.bsel)
            B_REG:   op_b = rd_b;
            B_ONE:   op_b = WIDTH'(1);
            B_ZERO:  op_b = '0;
            default: op_b = K_LIMIT;
        endcase
        case (ctrl.wdsel)
            W_ALU:   wr_data = alu_y;
            W_WIN:   wr_data = '1;
            W_LOSE:  wr_data = '0;
            default: wr_data = K_DRAW;
        endcase
    end

    assign p1_score  = taps[0];
    assign p2_score  = taps[1];
    assign tally     = taps[2];
    assign time_left = taps[3];
endmodule

// File: rtl/duel_tally_checker.sv
module duel_tally_checker #(
    parameter int unsigned WIDTH     = 16,
    parameter int unsigned TIME_INIT = 30
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] p1_score,
    input logic [WIDTH-1:0] p2_score,
    input logic [WIDTH-1:0] tally,
    input logic [WIDTH-1:0] time_left,
    input logic             game_over
);
    localparam logic [WIDTH-1:0] ALL1 = '1;
    localparam logic [WIDTH-1:0] TIE  = WIDTH'(16'h000F);

    a_r1_clear_after_restart: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (p1_score == '0 && p2_score == '0 && tally == '0 && !game_over));

    a_r2_tally_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && tally != $past(tally)) |-> (tally == $past(tally) + 1'b1 || tally == '0));

    a_r5_clock_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && time_left != $past(time_left))
            |-> (time_left == $past(time_left) - 1'b1 || time_left == WIDTH'(TIME_INIT)));

    a_r5_clock_bound: assert property (@(posedge clk) disable iff (rst)
        time_left <= WIDTH'(TIME_INIT));

    a_r7_verdict_codes: assert property (@(posedge clk) disable iff (rst)
        $rose(game_over) |-> ((p1_score == ALL1 && p2_score == '0) ||
                              (p1_score == '0 && p2_score == ALL1) ||
                              (p1_score == TIE && p2_score == TIE)));

    a_r9_end_frozen: assert property (@(posedge clk) disable iff (rst)
        game_over |=> (game_over && $stable(p1_score) && $stable(p2_score) &&
                       $stable(tally) && $stable(time_left)));
endmodule

bind duel_tally_core duel_tally_checker #(.WIDTH(WIDTH), .TIME_INIT(TIME_INIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .p1_score  (p1_score),
    .p2_score  (p2_score),
    .tally     (tally),
    .time_left (time_left),
    .game_over (game_over)
);

// File: tb/sim_duel_tally_core.sv
module sim_duel_tally_core;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit1 = 1'b0, hit2 = 1'b0, sec_tick = 1'b0, bump = 1'b0;
    logic [15:0] p1_score, p2_score, tally, time_left;
    logic game_over;

    int checks = 0;
    int errors = 0;

    // bench model of the game
    int  m_s1, m_s2, m_tally, m_time, m_u1, m_u2;
    bit  m_over;

    always #2 clk = ~clk;

    duel_tally_core u0 (
        .clk(clk), .rst(rst), .hit1(hit1), .hit2(hit2), .sec_tick(sec_tick), .bump(bump),
        .p1_score(p1_score), .p2_score(p2_score), .tally(tally), .time_left(time_left),
        .game_over(game_over)
    );

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "p1_score",  p1_score,  16'(m_s1));
        check(req, "p2_score",  p2_score,  16'(m_s2));
        check(req, "tally",     tally,     16'(m_tally));
        check(req, "time_left", time_left, 16'(m_time));
        check(req, "game_over", {15'd0, game_over}, {15'd0, m_over});
    endtask

    task automatic m_verdict();
        if (m_s1 > m_s2)      begin m_s1 = 16'hFFFF; m_s2 = 0; end
        else if (m_s2 > m_s1) begin m_s1 = 0; m_s2 = 16'hFFFF; end
        else                  begin m_s1 = 16'h000F; m_s2 = 16'h000F; end
        m_over = 1;
    endtask

    task automatic m_press(input int who);
        if (m_over) return;
        if (who == 1 && m_u1 < 3) begin m_s1 += m_tally; m_tally = 0; m_u1++; end
        else if (who == 2 && m_u2 < 3) begin m_s2 += m_tally; m_tally = 0; m_u2++; end
        else return;
        if (m_u1 == 3 && m_u2 == 3) m_verdict();
    endtask

    task automatic m_tick();
        if (m_over) return;
        if (m_time == 0) m_verdict(); else m_time--;
    endtask

    task automatic m_bump();
        if (!m_over) m_tally++;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive a set of pulses for one cycle: {bump, tick, hit2, hit1}
    task automatic fire(input logic [3:0] m, input int gap);
        @(negedge clk);
        {bump, sec_tick, hit2, hit1} = m;
        @(negedge clk);
        {bump, sec_tick, hit2, hit1} = 4'b0000;
        wait_cyc(gap);
    endtask

    task automatic do_bumps(input int n);
        for (int i = 0; i < n; i++) begin fire(4'b1000, 4); m_bump(); end
    endtask

    task automatic do_press(input int who);
        fire(who == 1 ? 4'b0001 : 4'b0010, 24);
        m_press(who);
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin fire(4'b0100, 6); m_tick(); end
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        m_s1 = 0; m_s2 = 0; m_tally = 0; m_u1 = 0; m_u2 = 0; m_over = 0; m_time = 0;
        wait_cyc(3);
        check_all("R1");
        rst = 1'b0;
        wait_cyc(4);
        m_time = 30;
        check_all("R1");
    endtask

    task automatic t_bumps();
        do_bumps(5);
        check_all("R2");
    endtask

    task automatic t_collect();
        do_press(1);
        check_all("R3");
    endtask

    task automatic t_priority();
        do_bumps(4);
        fire(4'b1111, 30);
        m_press(1); m_press(2); m_tick(); m_bump();
        check_all("R8");
    endtask

    task automatic t_latch();
        @(negedge clk); hit2 = 1'b1;
        @(negedge clk); hit2 = 1'b0;
        @(negedge clk); bump = 1'b1;
        @(negedge clk); bump = 1'b0;
        wait_cyc(24);
        m_press(2); m_bump();
        check_all("R8");
    endtask

    task automatic t_ticks();
        do_ticks(3);
        check_all("R5");
    endtask

    task automatic t_exhausted();
        do_bumps(2); do_press(1);
        check_all("R3");
        do_bumps(2); do_press(1);
        check_all("R4");
    endtask

    task automatic t_early_end();
        do_bumps(1); do_press(2);
        check_all("R6");
        check("R7", "p1 verdict", p1_score, 16'hFFFF);
        check("R7", "p2 verdict", p2_score, 16'h0000);
    endtask

    task automatic t_frozen();
        do_bumps(2); do_ticks(2); do_press(1);
        check_all("R9");
        check("R9", "game_over held", {15'd0, game_over}, 16'd1);
    endtask

    task automatic t_draw_by_time();
        t_reset();
        do_bumps(3); do_press(1);
        do_bumps(3); do_press(2);
        do_ticks(30);
        check_all("R5");
        do_ticks(1);
        wait_cyc(20);
        check_all("R5");
        check("R7", "draw p1", p1_score, 16'h000F);
        check("R7", "draw p2", p2_score, 16'h000F);
    endtask

    task automatic t_p2_by_time();
        t_reset();
        do_bumps(2); do_press(2);
        do_ticks(31);
        wait_cyc(20);
        check_all("R7");
        check("R7", "p2 wins", p2_score, 16'hFFFF);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_bumps();
        t_collect();
        t_priority();
        t_latch();
        t_ticks();
        t_exhausted();
        t_early_end();
        t_frozen();
        t_draw_by_time();
        t_p2_by_time();
        summary();
        $finish;
    end
endmodule